// File: doc/BRIEF.md
# NMI Source Control and System Status Ports

This block decides when the processor receives a non-maskable interrupt. Two error sources feed it. The first is a one-cycle error pulse from the memory parity checker. The second is an external active-low channel-check line, which a board holds low until its own handler releases it. The block captures each source in a sticky flag, but only while that source's enable is active. The enable bits are active low: 1 disables the source. An active-low NMI line is driven whenever an enabled flag is set and the separate mask bit is clear.

Software reaches the block through a plain I/O bus, which has an address, read and write strobes, and 8-bit write and read data. Two port addresses are decoded. The system control port (default 61h) holds the two source enables and two storage bits for the timer and speaker, and it reports both error flags on a read. The index port (default 70h) holds the NMI mask bit, which cannot be read back, and a 7-bit index into the CMOS RAM. To clear a pending error, software writes the matching enable bit to 1 and then back to 0.

Top module: `nmi_status_ports`

## Requirements
- R1: After reset, a read of the system port returns 0x0C, a read of the index port returns 0x00, and `nmi_n` is 1. Both sources are disabled and NMI is masked.
- R2: System port writes store data bits 3..0: bit 3 disables channel check, bit 2 disables parity, and bits 1 and 0 are plain storage. A read returns these four bits in the same positions, with bits 5 and 4 reading 0. Written bits 7..4 are ignored.
- R3: An index port write stores bit 7 as the NMI mask and bits 6..0 as the CMOS index. A read returns the index in bits 6..0 and always returns 0 in bit 7.
- R4: A parity pulse sampled while bit 2 is 0 sets the parity flag on the next clock edge. The flag reads as bit 7 of the system port and stays set after the pulse ends.
- R5: A parity pulse sampled while bit 2 is 1 has no effect: bit 7 stays 0, and `nmi_n` stays 1.
- R6: A low level on `chck_n` while bit 3 is 0 sets the channel flag no later than SYNC_STAGES+1 clocks later. The flag reads as bit 6 of the system port and stays set after `chck_n` returns high.
- R7: `nmi_n` is 0 exactly when the mask is 0 and at least one flag is set. It is 1 when no flag is set.
- R8: While the mask bit is 1, `nmi_n` is 1 whatever the flags hold. Writing the mask back to 0 brings a pending NMI back.
- R9: While bit 2 is 1 the parity flag is clear, and while bit 3 is 1 the channel flag is clear. Writing the bit back to 0 leaves the flag clear unless the source is active again.
- R10: A low level on `chck_n` while bit 3 is 1 has no effect: bit 6 stays 0, and `nmi_n` stays 1.
- R11: `io_rdata` is 0 when `io_rd` is low, and 0 during a read of any other address.
- R12: Writes to any other address leave both ports and `nmi_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_rd | input | 1 | Read strobe, active high |
| io_wr | input | 1 | Write strobe, active high, sampled at the clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational while `io_rd` is high |
| par_err | input | 1 | Parity error pulse from the parity checker |
| chck_n | input | 1 | External channel check, active low, asynchronous |
| nmi_n | output | 1 | Non-maskable interrupt to the CPU, active low |

## Verification
A flag that failed to latch, or that was cleared early, shows up on the very next read of the system port as a wrong bit 7 or bit 6. It also shows at once on `nmi_n` whenever the mask is open. A mask or enable held in the wrong polarity inverts `nmi_n` in the same cycle that a flag is set. For the channel line, the error appears within the synchronizer delay plus one clock. Stale enable or storage bits appear as a wrong low nibble on the next system-port read. Any decode mistake changes either the read data or the state seen on later reads.

// File: rtl/nmi_pkg.sv
`timescale 1ns/1ps
package nmi_pkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = 7;

  // Bit positions of the system control port; software and the bench rely on them.
  localparam int SYS_PAR_FLAG = 7;
  localparam int SYS_CHK_FLAG = 6;
  localparam int SYS_CC_DIS   = 3;
  localparam int SYS_PC_DIS   = 2;
  localparam int SYS_SPK      = 1;
  localparam int SYS_GATE     = 0;
  localparam int IDX_MASK_BIT = 7;

  typedef struct packed {
    logic cc_dis;
    logic pc_dis;
    logic spk_en;
    logic t2_gate;
  } sys_bits_t;

  localparam sys_bits_t SYS_RESET = '{cc_dis: 1'b1, pc_dis: 1'b1, spk_en: 1'b0, t2_gate: 1'b0};

  function automatic logic addr_hit(input logic [31:0] addr, input logic [31:0] port);
    return addr == port;
  endfunction

  // Read image of the system port built from live flags and stored bits.
  function automatic logic [DATA_W-1:0] pack_sys(input logic par_f, input logic chk_f,
                                                 input sys_bits_t s);
    logic [DATA_W-1:0] v;
    v = '0;
    v[SYS_PAR_FLAG] = par_f;
    v[SYS_CHK_FLAG] = chk_f;
    v[SYS_CC_DIS]   = s.cc_dis;
    v[SYS_PC_DIS]   = s.pc_dis;
    v[SYS_SPK]      = s.spk_en;
    v[SYS_GATE]     = s.t2_gate;
    return v;
  endfunction

  // Active-low interrupt request from both gated sources and the mask.
  function automatic logic nmi_level_n(input logic par_f, input logic pc_dis,
                                       input logic chk_f, input logic cc_dis,
                                       input logic mask);
    return !(!mask && ((par_f && !pc_dis) || (chk_f && !cc_dis)));
  endfunction

endpackage

// File: rtl/nmi_sync.sv
`timescale 1ns/1ps
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic level
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= !async_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
endmodule

// File: rtl/nmi_sysctl_reg.sv
`timescale 1ns/1ps
module nmi_sysctl_reg
  import nmi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [3:0] wdata,
  output sys_bits_t bits
);
  sys_bits_t bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     bits_q <= SYS_RESET;
    else if (wr_en) bits_q <= sys_bits_t'(wdata);
  end

  assign bits = bits_q;

  AST_SYS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bits_q)); // R12
  AST_SYS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bits_q == $past(wdata))); // R2
endmodule

// File: rtl/nmi_idx_reg.sv
`timescale 1ns/1ps
module nmi_idx_reg
  import nmi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              mask,
  output logic [IDX_W-1:0]  index
);
  logic             mask_q;
  logic [IDX_W-1:0] index_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= 1'b1;
      index_q <= '0;
    end else if (wr_en) begin
      mask_q  <= wdata[IDX_MASK_BIT];
      index_q <= wdata[IDX_W-1:0];
    end
  end

  assign mask  = mask_q;
  assign index = index_q;

  AST_IDX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mask_q) && $stable(index_q))); // R12
endmodule

// File: rtl/nmi_err_latch.sv
`timescale 1ns/1ps
module nmi_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic dis,
  output logic flag
);
  logic flag_q;
  logic set_ev;
  logic clr_ev;

  assign set_ev = src && !dis;
  assign clr_ev = dis;

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (clr_ev) flag_q <= 1'b0;
    else if (set_ev) flag_q <= 1'b1;
  end

  assign flag = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (src && !dis) |=> flag_q); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !dis) |=> flag_q); // R6
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> !flag_q); // R9
endmodule

// File: rtl/nmi_status_ports.sv
`timescale 1ns/1ps
module nmi_status_ports
  import nmi_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter logic [31:0] SYS_PORT    = 32'h61,
  parameter logic [31:0] IDX_PORT    = 32'h70,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              par_err,
  input  logic              chck_n,
  output logic              nmi_n
);
  logic             hit_sys;
  logic             hit_idx;
  logic             wr_sys;
  logic             wr_idx;
  sys_bits_t        sys_bits;
  logic             mask;
  logic [IDX_W-1:0] index;
  logic             chk_level;
  logic             par_flag;
  logic             chk_flag;

  assign hit_sys = addr_hit(32'(io_addr), SYS_PORT);
  assign hit_idx = addr_hit(32'(io_addr), IDX_PORT);
  assign wr_sys  = io_wr && hit_sys;
  assign wr_idx  = io_wr && hit_idx;

  nmi_sysctl_reg u_sys (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_sys),
    .wdata (io_wdata[3:0]),
    .bits  (sys_bits)
  );

  nmi_idx_reg u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_idx),
    .wdata (io_wdata),
    .mask  (mask),
    .index (index)
  );

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (chck_n),
    .level   (chk_level)
  );

  nmi_err_latch u_par (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (par_err),
    .dis   (sys_bits.pc_dis),
    .flag  (par_flag)
  );

  nmi_err_latch u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (chk_level),
    .dis   (sys_bits.cc_dis),
    .flag  (chk_flag)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (hit_sys)      io_rdata = pack_sys(par_flag, chk_flag, sys_bits);
      else if (hit_idx) io_rdata = {1'b0, index};
    end
  end

  assign nmi_n = nmi_level_n(par_flag, sys_bits.pc_dis, chk_flag, sys_bits.cc_dis, mask);

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> nmi_n); // R8
  AST_NO_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_flag && !chk_flag) |-> nmi_n); // R7
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00)); // R11
  AST_IDX_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit_idx) |-> !io_rdata[7]); // R3
endmodule

// File: tb/tb_nmi_status_ports.sv
`timescale 1ns/1ps
module tb_nmi_status_ports;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        par_err = 1'b0;
  logic        chck_n = 1'b1;
  logic        nmi_n;
  logic        mon_req = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [7:0] rdata;
    logic       nmi;
    int         req;
  } item_t;

  item_t q[$];
  item_t cur;

  always #10 clk = ~clk;

  nmi_status_ports dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .par_err(par_err), .chck_n(chck_n),
    .nmi_n(nmi_n)
  );

  // Monitor: pops one expected item per requested sample, at the falling edge.
  always @(negedge clk) begin
    if (mon_req) begin
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: actual rdata=%h nmi_n=%b expected an item", io_rdata, nmi_n);
      end else begin
        cur = q.pop_front();
        n_cmp++;
        if (io_rdata !== cur.rdata || nmi_n !== cur.nmi)
          begin
            n_bad++;
            $display("FAIL R%0d: actual rdata=%h nmi_n=%b expected rdata=%h nmi_n=%b",
                     cur.req, io_rdata, nmi_n, cur.rdata, cur.nmi);
          end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #2;
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input logic en, input int r);
    @(posedge clk); #2;
    io_addr = a; io_rd = 1'b1; mon_req = 1'b1;
    q.push_back('{rdata: e, nmi: en, req: r});
    @(posedge clk); #2;
    io_rd = 1'b0; mon_req = 1'b0;
  endtask

  task automatic idle_chk(input logic [15:0] a, input logic en, input int r);
    @(posedge clk); #2;
    io_addr = a; mon_req = 1'b1;
    q.push_back('{rdata: 8'h00, nmi: en, req: r});
    @(posedge clk); #2;
    mon_req = 1'b0;
  endtask

  task automatic par_pulse();
    @(posedge clk); #2; par_err = 1'b1;
    @(posedge clk); #2; par_err = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    rd(16'h61, 8'h0C, 1'b1, 1);          // R1 reset image of the system port
    rd(16'h70, 8'h00, 1'b1, 1);          // R1 index cleared

    wr(16'h61, 8'h0F);
    rd(16'h61, 8'h0F, 1'b1, 2);          // R2 low nibble stored
    wr(16'h61, 8'hF3);
    rd(16'h61, 8'h03, 1'b1, 2);          // R2 upper written bits dropped, both enabled

    wr(16'h70, 8'hA5);
    rd(16'h70, 8'h25, 1'b1, 3);          // R3 index readback, bit 7 reads 0

    par_pulse();
    rd(16'h61, 8'h83, 1'b1, 4);          // R4 flag latched; R8 masked
    wr(16'h70, 8'h25);
    rd(16'h61, 8'h83, 1'b0, 7);          // R7 NMI with mask open
    wr(16'h70, 8'hA5);
    rd(16'h70, 8'h25, 1'b1, 8);          // R8 mask quiets NMI
    wr(16'h70, 8'h00);
    rd(16'h70, 8'h00, 1'b0, 8);          // R8 pending NMI returns after unmask

    wr(16'h61, 8'h07);
    rd(16'h61, 8'h07, 1'b1, 9);          // R9 parity flag cleared by disable
    wr(16'h61, 8'h03);
    rd(16'h61, 8'h03, 1'b1, 9);          // R9 stays clear after re-enable

    wr(16'h61, 8'h07);
    par_pulse();
    rd(16'h61, 8'h07, 1'b1, 5);          // R5 pulse ignored while disabled
    wr(16'h61, 8'h03);
    rd(16'h61, 8'h03, 1'b1, 5);          // R5 nothing left pending

    chck_n = 1'b0;
    wait_clk(4);
    rd(16'h61, 8'h43, 1'b0, 6);          // R6 channel flag set, NMI active
    chck_n = 1'b1;
    wait_clk(4);
    rd(16'h61, 8'h43, 1'b0, 6);          // R6 sticky after line released
    wr(16'h61, 8'h0B);
    rd(16'h61, 8'h0B, 1'b1, 9);          // R9 channel flag cleared
    wr(16'h61, 8'h03);
    rd(16'h61, 8'h03, 1'b1, 9);          // R9 stays clear

    wr(16'h61, 8'h0B);
    chck_n = 1'b0;
    wait_clk(4);
    rd(16'h61, 8'h0B, 1'b1, 10);         // R10 ignored while disabled
    chck_n = 1'b1;
    wait_clk(4);
    wr(16'h61, 8'h03);
    rd(16'h61, 8'h03, 1'b1, 10);         // R10 nothing latched

    chck_n = 1'b0;
    par_pulse();
    wait_clk(3);
    rd(16'h61, 8'hC3, 1'b0, 7);          // R7 both sources at once
    chck_n = 1'b1;
    wait_clk(4);
    wr(16'h61, 8'h0F);
    wr(16'h61, 8'h03);
    rd(16'h61, 8'h03, 1'b1, 9);          // R9 both cleared together

    rd(16'h62, 8'h00, 1'b1, 11);         // R11 other address reads 0
    idle_chk(16'h61, 1'b1, 11);          // R11 no strobe, no data

    wr(16'h71, 8'hFF);
    wr(16'h60, 8'hFF);
    rd(16'h61, 8'h03, 1'b1, 12);         // R12 system port untouched
    rd(16'h70, 8'h00, 1'b1, 12);         // R12 index port untouched

    wait_clk(2);
    finish_run();
  end
endmodule